// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block gathers the interrupt conditions of a serial port into one request line and a four-bit identification value. Five conditions compete: receiver line errors, received data (or, with the receive queue enabled, a fill threshold), a receive idle timeout, an empty transmit holding register, and a change on a modem status input. Each condition has an enable. The identification value names only the most urgent enabled condition. Its lowest bit is an active-low pending flag.

The surrounding port supplies the receive queue occupancy, push and pop strobes, a 16x baud tick and the frame format. From these inputs the block derives the fill-threshold test and a four-character idle timer. It keeps its own record of the transmit-empty event, because that event is cleared by accesses and not by a level. The outgoing request is passed only while a user output bit is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir` reads 4'b0001 and `irq` is 0.
- R2: `iir[0]` is 0 in the cycle after any enabled source is active and 1 when none is. `iir` is registered and follows its inputs one clock later.
- R3: `iir[3:1]` reports only the highest-priority active source. From highest to lowest the codes are: line error 011, received data 010, idle timeout 110, transmit empty 001, modem change 000.
- R4: When `fifo_mode` is 0, `iir[3]` is always 0 and the idle timeout never fires.
- R5: The received-data source is active when `rx_count` is at least the threshold. Outside FIFO mode the threshold is 1. In FIFO mode `trig_sel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14. The source goes inactive as soon as the count falls below the threshold.
- R6: In FIFO mode with `rx_count` nonzero, the timeout source becomes active once `64 * (7 + word_len + parity_en + two_stop)` ticks of `tick16` have passed with no push or pop. A push, a pop or an empty queue restarts the count and drops the source.
- R7: The transmit-empty source is latched on a rising edge of `thr_empty`, with the first cycle after reset counting as a rising edge if the input is high. It is cleared by `thr_write`, or by `iir_read` in a cycle where `iir` reads 4'b0010. If a clear and a set happen in the same cycle, the clear wins.
- R8: `irq` is 1 exactly when `iir[0]` is 0 and `out2` was 1 in the same sampling cycle. While `out2` is 0, `irq` stays 0.
- R9: A source whose enable is 0 has no effect on `iir` or `irq`. The timeout uses the received-data enable `en_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | Receive/transmit queues enabled |
| en_rx | input | 1 | Enable for received data and timeout |
| en_thre | input | 1 | Enable for transmit-empty |
| en_line | input | 1 | Enable for line errors |
| en_modem | input | 1 | Enable for modem change |
| trig_sel | input | 2 | Receive threshold select |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Extra stop bit |
| tick16 | input | 1 | 16x baud tick |
| rx_count | input | 5 | Receive queue occupancy |
| rx_push | input | 1 | Character entered the receive queue |
| rx_pop | input | 1 | Character read from the receive queue |
| line_err | input | 1 | Any line error flag held |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_write | input | 1 | Write to transmit holding register |
| iir_read | input | 1 | Identification register read |
| modem_delta | input | 1 | Any modem change flag held |
| out2 | input | 1 | User output bit gating the request |
| iir | output | 4 | {id[2:0], pending_n} |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest condition to reach is the idle timeout. It needs a nonzero, unchanging queue level and a long run of ticks with no other source above it. The stimulus holds the queue at a level below the 14-character threshold with `tick16` high every cycle, so the 640-tick window is crossed directly. A pop then confirms the clear. Reaching the transmit-empty read-clear requires a read strobe in a cycle where that source is the one reported, so the bench first quiets every higher source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  localparam int SRC_N     = 5;
  localparam int S_LINE    = 0;
  localparam int S_RXDATA  = 1;
  localparam int S_TIMEOUT = 2;
  localparam int S_THRE    = 3;
  localparam int S_MODEM   = 4;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0: trig_level = 5'd1;
      2'd1: trig_level = 5'd4;
      2'd2: trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

  function automatic logic [3:0] frame_bits(input logic [1:0] wl, input logic par,
                                            input logic stop2);
    frame_bits = 4'd7 + {2'b00, wl} + {3'b000, par} + {3'b000, stop2};
  endfunction
endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tick,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             two_stop,
  output logic             timeout
);
  logic [TMR_W-1:0] idle_cnt;
  logic [TMR_W-1:0] limit;
  logic             restart;

  assign limit   = TMR_W'({frame_bits(word_len, parity_en, two_stop), 6'd0});
  assign restart = !fifo_mode || (rx_count == '0) || rx_push || rx_pop;

  always_ff @(posedge clk) begin
    if (rst || restart) idle_cnt <= '0;
    else if (tick && idle_cnt < limit) idle_cnt <= idle_cnt + 1'b1;
  end

  assign timeout = fifo_mode && (rx_count != '0) && (idle_cnt >= limit);

  // R6
  pop_clears_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !timeout);
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty,
  input  logic thr_write,
  input  logic read_ack,
  output logic flag
);
  logic empty_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_d <= 1'b0;
      flag    <= 1'b0;
    end else begin
      empty_d <= thr_empty;
      if (thr_write || read_ack) flag <= 1'b0;
      else if (thr_empty && !empty_d) flag <= 1'b1;
    end
  end

  // R7
  write_clears_thre_chk: assert property (@(posedge clk) disable iff (rst)
    thr_write |=> !flag);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_mode,
  input  logic              out2,
  input  logic [SRC_N-1:0]  src,
  output logic [3:0]        iir,
  output logic              irq
);
  irq_id_e id_n;
  logic    any_n;

  always_comb begin
    any_n = |src;
    if (src[S_LINE])         id_n = ID_LINE;
    else if (src[S_RXDATA])  id_n = ID_RXDATA;
    else if (src[S_TIMEOUT]) id_n = ID_TIMEOUT;
    else if (src[S_THRE])    id_n = ID_THRE;
    else                     id_n = ID_MODEM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir <= 4'b0001;
      irq <= 1'b0;
    end else begin
      iir <= {id_n[2] & fifo_mode, id_n[1:0], ~any_n};
      irq <= any_n & out2;
    end
  end

  // R3
  line_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(src[S_LINE]) |-> iir[3:1] == 3'b011);
  // R4
  char_mode_bit3_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_mode) |-> !iir[3]);
  // R8
  out2_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(out2) |-> !irq);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             en_rx,
  input  logic             en_thre,
  input  logic             en_line,
  input  logic             en_modem,
  input  logic [1:0]       trig_sel,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             two_stop,
  input  logic             tick16,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             line_err,
  input  logic             thr_empty,
  input  logic             thr_write,
  input  logic             iir_read,
  input  logic             modem_delta,
  input  logic             out2,
  output logic [3:0]       iir,
  output logic             irq
);
  logic             timeout;
  logic             thre_flag;
  logic             rx_hit;
  logic [CNT_W-1:0] level;
  logic [SRC_N-1:0] src;

  assign level  = fifo_mode ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1);
  assign rx_hit = rx_count >= level;

  assign src[S_LINE]    = en_line  & line_err;
  assign src[S_RXDATA]  = en_rx    & rx_hit;
  assign src[S_TIMEOUT] = en_rx    & timeout;
  assign src[S_THRE]    = en_thre  & thre_flag;
  assign src[S_MODEM]   = en_modem & modem_delta;

  uart_irq_timeout #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_tmo (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .rx_count(rx_count),
    .rx_push(rx_push), .rx_pop(rx_pop), .tick(tick16), .word_len(word_len),
    .parity_en(parity_en), .two_stop(two_stop), .timeout(timeout));

  uart_irq_thre u_thre (
    .clk(clk), .rst(rst), .thr_empty(thr_empty), .thr_write(thr_write),
    .read_ack(iir_read && iir == 4'b0010), .flag(thre_flag));

  uart_irq_prio u_prio (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .out2(out2), .src(src),
    .iir(iir), .irq(irq));

  // R9
  disabled_modem_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(src) == '0) |-> iir[0]);
endmodule

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
  logic clk = 0, rst = 1;
  logic fifo_mode = 0, en_rx = 0, en_thre = 0, en_line = 0, en_modem = 0;
  logic [1:0] trig_sel = 0, word_len = 0;
  logic parity_en = 0, two_stop = 0, tick16 = 0;
  logic [4:0] rx_count = 0;
  logic rx_push = 0, rx_pop = 0, line_err = 0, thr_empty = 0, thr_write = 0;
  logic iir_read = 0, modem_delta = 0, out2 = 0;
  logic [3:0] iir;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident uut (.*);

  // Behavioural reference
  int m_cnt = 0;
  bit m_thre = 0, m_prev = 0;
  logic [3:0] exp_iir = 4'b0001;
  bit exp_irq = 0;

  always @(posedge clk) begin
    int lim, lvl;
    bit to, rda, any;
    logic [3:0] old;
    if (rst) begin
      m_cnt = 0; m_thre = 0; m_prev = 0; exp_iir = 4'b0001; exp_irq = 0;
    end else begin
      old = exp_iir;
      lim = 64 * (7 + word_len + parity_en + two_stop);
      case (trig_sel) 0: lvl = 1; 1: lvl = 4; 2: lvl = 8; default: lvl = 14; endcase
      if (!fifo_mode) lvl = 1;
      rda = en_rx && (rx_count >= lvl);
      to  = en_rx && fifo_mode && rx_count != 0 && m_cnt >= lim;
      any = 1;
      if (en_line && line_err)        exp_iir = 4'b0110;
      else if (rda)                   exp_iir = 4'b0100;
      else if (to)                    exp_iir = 4'b1100;
      else if (en_thre && m_thre)     exp_iir = 4'b0010;
      else if (en_modem && modem_delta) exp_iir = 4'b0000;
      else begin exp_iir = 4'b0001; any = 0; end
      exp_irq = any && out2;
      if (thr_write || (iir_read && old == 4'b0010)) m_thre = 0;
      else if (thr_empty && !m_prev) m_thre = 1;
      m_prev = thr_empty;
      if (!fifo_mode || rx_count == 0 || rx_push || rx_pop) m_cnt = 0;
      else if (tick16 && m_cnt < lim) m_cnt++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      tests++;
      if (iir !== exp_iir || irq !== exp_irq) begin
        fails++;
        $display("FAIL R2/R3 model: iir=%b irq=%b expected iir=%b irq=%b",
                 iir, irq, exp_iir, exp_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3); rst = 0;
    chk("R1 reset", {iir, irq}, 5'b00010);
    // transmit empty rising with request gated on
    en_thre = 1; thr_empty = 1; out2 = 1; cyc(3);
    chk("R7 set", {iir, irq}, 5'b00101);
    chk("R8 pass", {4'b0, irq}, 5'b00001);
    out2 = 0; cyc(2);
    chk("R8 gate", {iir, irq}, 5'b00100);
    iir_read = 1; cyc(1); iir_read = 0; cyc(2);
    chk("R7 read clear", {iir, irq}, 5'b00010);
    // modem masked then enabled
    out2 = 1; modem_delta = 1; cyc(3);
    chk("R9 mask", {iir, irq}, 5'b00010);
    en_modem = 1; cyc(2);
    chk("R3 modem", {iir, irq}, 5'b00001);
    // line over data, then data
    en_rx = 1; en_line = 1; line_err = 1; rx_count = 1; cyc(2);
    chk("R3 line", {iir, irq}, 5'b01101);
    line_err = 0; cyc(2);
    chk("R3 rxdata", {iir, irq}, 5'b01001);
    // thre re-set below rx data, write clears
    thr_empty = 0; cyc(1); thr_empty = 1; cyc(3);
    chk("R3 data over thre", {iir, irq}, 5'b01001);
    rx_count = 0; cyc(2);
    chk("R3 thre over modem", {iir, irq}, 5'b00101);
    thr_write = 1; cyc(1); thr_write = 0; cyc(2);
    chk("R7 write clear", {iir, irq}, 5'b00001);
    modem_delta = 0; cyc(2);
    chk("R2 none", {iir, irq}, 5'b00010);
    // thresholds in FIFO mode
    fifo_mode = 1; trig_sel = 2; rx_count = 7; rx_push = 1; cyc(1); rx_push = 0; cyc(2);
    chk("R5 below 8", {iir, irq}, 5'b00010);
    rx_count = 8; cyc(2);
    chk("R5 at 8", {iir, irq}, 5'b01001);
    trig_sel = 3; cyc(2);
    chk("R5 below 14", {iir, irq}, 5'b00010);
    // idle timeout: 8 data bits, 1 stop, no parity -> 640 ticks
    trig_sel = 3; word_len = 3; rx_count = 3; tick16 = 1; cyc(600);
    chk("R6 early", {iir, irq}, 5'b00010);
    cyc(60);
    chk("R6 fired", {iir, irq}, 5'b11001);
    en_rx = 0; cyc(2);
    chk("R9 timeout mask", {iir, irq}, 5'b00010);
    en_rx = 1; cyc(2);
    rx_pop = 1; rx_count = 2; cyc(1); rx_pop = 0; cyc(2);
    chk("R6 pop clear", {iir, irq}, 5'b00010);
    // character mode: no timeout, bit3 low
    fifo_mode = 0; cyc(800);
    chk("R4 char mode", {iir, irq}, 5'b01001);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule